// File: doc/BRIEF.md
# Windowed Readout Row and Column Addressing

This block generates the row and column pointers that walk an image array during readout. A start word arrives serially: one data bit per rising edge of a serial clock input. A load strobe then copies the column half and the row half of that word into two start registers. A row sync pulse places the row pointer on the row start, and each rising edge of the row clock moves it down one line. The column pointer works the same way, with its own sync and clock inputs.

The sync pulses both begin a new window and close the previous one, so the spacing between them sets the window size. When the whole array is being read, single-cycle end-of-scan flags mark the arrival on the last column and on the last row. A window with any nonzero start never raises these flags. All inputs are sampled on one system clock, and the clock-like inputs are edge-detected against that clock.

Top module: `rdo_window_addr`

## Requirements
- R1: A synchronous active-high reset clears both pointers, both start registers, the serial shift register and both end-of-scan flags. All outputs are registered.
- R2: Each rising edge of `ser_clk` shifts `ser_dat` into a 21-bit register, MSB first. After 21 edges, bits [20:10] hold the column start and bits [9:0] hold the row start.
- R3: A cycle with `load_addr` high copies the shift register fields into the start registers. The shift register contents used are those from before any shift in the same cycle.
- R4: A cycle with `row_sync` high loads the row pointer from the row start. A cycle with `col_sync` high loads the column pointer from the column start. The pointer shows the new value after the next clock edge.
- R5: Each rising edge of `row_clk` adds one to the row pointer. Holding `row_clk` high does not step it again.
- R6: Each rising edge of `col_clk` adds one to the column pointer. Holding `col_clk` high does not step it again.
- R7: When a sync pulse and a clock rising edge meet in one cycle, the sync wins and the pointer takes the start value.
- R8: When `load_addr` and a sync pulse meet in one cycle, the pointer takes the newly loaded start value.
- R9: `col_eos` is high for exactly one cycle, the cycle in which a step brings `col_ptr` to 1279.
- R10: `row_eos` is high for exactly one cycle, the cycle in which a step brings `row_ptr` to 1023.
- R11: While either start register is nonzero (windowing), neither end-of-scan flag is raised.
- R12: A step from the last column (1279) or the last row (1023) wraps the pointer to 0 and raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk | input | 1 | Serial shift clock, rising edge detected |
| ser_dat | input | 1 | Serial start-address data |
| load_addr | input | 1 | Copy shifted word into start registers |
| row_sync | input | 1 | Restart row pointer at row start |
| row_clk | input | 1 | Row step, rising edge detected |
| col_sync | input | 1 | Restart column pointer at column start |
| col_clk | input | 1 | Column step, rising edge detected |
| row_ptr | output | 10 | Current row address |
| col_ptr | output | 11 | Current column address |
| row_eos | output | 1 | Last row of full frame reached |
| col_eos | output | 1 | Last column of full line reached |

## Verification
Two pairs of events can land in the same cycle. A sync pulse can coincide with a rising edge of its step clock, and a load strobe can coincide with a sync pulse. The bench drives both pairs in one cycle on purpose. It checks that the pointer shows the start value rather than an incremented one, and in the second case that it shows the freshly loaded start. A per-cycle reference model, built from the requirements, predicts every output.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
  typedef enum logic [1:0] {
    PA_HOLD = 2'd0,
    PA_LOAD = 2'd1,
    PA_STEP = 2'd2
  } ptr_act_e;
endpackage

// File: rtl/rdo_addr_loader.sv
module rdo_addr_loader #(
  parameter int unsigned CW = 11,
  parameter int unsigned RW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ser_clk,
  input  logic          ser_dat,
  input  logic          load,
  output logic [CW-1:0] col_start_q,
  output logic [RW-1:0] row_start_q,
  output logic [CW-1:0] col_start_eff,
  output logic [RW-1:0] row_start_eff
);
  localparam int unsigned WW = CW + RW;

  logic [WW-1:0] shreg;
  logic          sclk_q;
  logic          shift_en;

  assign shift_en      = ser_clk & ~sclk_q;
  assign col_start_eff = load ? shreg[WW-1:RW] : col_start_q;
  assign row_start_eff = load ? shreg[RW-1:0]  : row_start_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg       <= '0;
      sclk_q      <= 1'b0;
      col_start_q <= '0;
      row_start_q <= '0;
    end else begin
      sclk_q <= ser_clk;
      if (shift_en) shreg <= {shreg[WW-2:0], ser_dat};
      col_start_q <= col_start_eff;
      row_start_q <= row_start_eff;
    end
  end
endmodule

// File: rtl/rdo_scan_pointer.sv
module rdo_scan_pointer
  import rdo_pkg::*;
#(
  parameter int unsigned W    = 11,
  parameter int unsigned LAST = 1279
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sync,
  input  logic         step_lvl,
  input  logic [W-1:0] start,
  input  logic         quiet,
  output logic [W-1:0] ptr,
  output logic         eos
);
  localparam logic [W-1:0] LAST_V = W'(LAST);
  localparam logic [W-1:0] PREV_V = W'(LAST - 1);

  logic     step_q;
  ptr_act_e act;
  logic [W-1:0] ptr_inc;

  always_comb begin
    if (sync)                  act = PA_LOAD;
    else if (step_lvl & ~step_q) act = PA_STEP;
    else                       act = PA_HOLD;
  end

  assign ptr_inc = (ptr == LAST_V) ? '0 : ptr + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= 1'b0;
      ptr    <= '0;
      eos    <= 1'b0;
    end else begin
      step_q <= step_lvl;
      case (act)
        PA_LOAD: begin
          ptr <= start;
          eos <= 1'b0;
        end
        PA_STEP: begin
          ptr <= ptr_inc;
          eos <= (ptr == PREV_V) & ~quiet;
        end
        default: eos <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/rdo_window_addr.sv
module rdo_window_addr #(
  parameter int unsigned N_COLS = 1280,
  parameter int unsigned N_ROWS = 1024
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ser_clk,
  input  logic                      ser_dat,
  input  logic                      load_addr,
  input  logic                      row_sync,
  input  logic                      row_clk,
  input  logic                      col_sync,
  input  logic                      col_clk,
  output logic [$clog2(N_ROWS)-1:0] row_ptr,
  output logic [$clog2(N_COLS)-1:0] col_ptr,
  output logic                      row_eos,
  output logic                      col_eos
);
  localparam int unsigned CW = $clog2(N_COLS);
  localparam int unsigned RW = $clog2(N_ROWS);

  logic [CW-1:0] col_start_q, col_start_eff;
  logic [RW-1:0] row_start_q, row_start_eff;
  logic          windowed;

  assign windowed = (|col_start_q) | (|row_start_q);

  rdo_addr_loader #(.CW(CW), .RW(RW)) u_loader (
    .clk           (clk),
    .rst           (rst),
    .ser_clk       (ser_clk),
    .ser_dat       (ser_dat),
    .load          (load_addr),
    .col_start_q   (col_start_q),
    .row_start_q   (row_start_q),
    .col_start_eff (col_start_eff),
    .row_start_eff (row_start_eff)
  );

  rdo_scan_pointer #(.W(CW), .LAST(N_COLS - 1)) u_col (
    .clk      (clk),
    .rst      (rst),
    .sync     (col_sync),
    .step_lvl (col_clk),
    .start    (col_start_eff),
    .quiet    (windowed),
    .ptr      (col_ptr),
    .eos      (col_eos)
  );

  rdo_scan_pointer #(.W(RW), .LAST(N_ROWS - 1)) u_row (
    .clk      (clk),
    .rst      (rst),
    .sync     (row_sync),
    .step_lvl (row_clk),
    .start    (row_start_eff),
    .quiet    (windowed),
    .ptr      (row_ptr),
    .eos      (row_eos)
  );
endmodule

// File: rtl/rdo_window_addr_chk.sv
module rdo_window_addr_chk #(
  parameter int unsigned N_COLS = 1280,
  parameter int unsigned N_ROWS = 1024
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      load_addr,
  input logic                      col_sync,
  input logic                      col_clk,
  input logic                      row_sync,
  input logic [$clog2(N_ROWS)-1:0] row_ptr,
  input logic [$clog2(N_COLS)-1:0] col_ptr,
  input logic                      row_eos,
  input logic                      col_eos,
  input logic [$clog2(N_COLS)-1:0] col_start_q,
  input logic [$clog2(N_ROWS)-1:0] row_start_q
);
  localparam int unsigned CW = $clog2(N_COLS);
  localparam int unsigned RW = $clog2(N_ROWS);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (col_ptr == '0 && row_ptr == '0 && !col_eos && !row_eos));

  a_r4_col_sync_start: assert property (@(posedge clk) disable iff (rst)
    (col_sync && !load_addr) |=> col_ptr == $past(col_start_q));

  a_r4_row_sync_start: assert property (@(posedge clk) disable iff (rst)
    (row_sync && !load_addr) |=> row_ptr == $past(row_start_q));

  a_r6_col_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !col_sync && col_clk && !$past(col_clk) && col_ptr != CW'(N_COLS - 1))
      |=> col_ptr == $past(col_ptr) + 1'b1);

  a_r9_col_eos_single: assert property (@(posedge clk) disable iff (rst)
    col_eos |=> !col_eos);

  a_r9_col_eos_last: assert property (@(posedge clk) disable iff (rst)
    col_eos |-> col_ptr == CW'(N_COLS - 1));

  a_r10_row_eos_single: assert property (@(posedge clk) disable iff (rst)
    row_eos |=> !row_eos);

  a_r10_row_eos_last: assert property (@(posedge clk) disable iff (rst)
    row_eos |-> row_ptr == RW'(N_ROWS - 1));

  a_r11_quiet_window: assert property (@(posedge clk) disable iff (rst)
    (col_eos || row_eos) |-> $past(col_start_q == '0 && row_start_q == '0));
endmodule

bind rdo_window_addr rdo_window_addr_chk #(.N_COLS(N_COLS), .N_ROWS(N_ROWS)) u_chk (.*);

// File: tb/test_rdo_window_addr.sv
module test_rdo_window_addr;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst, ser_clk, ser_dat, load_addr, row_sync, row_clk, col_sync, col_clk;
  logic [9:0]  row_ptr;
  logic [10:0] col_ptr;
  logic        row_eos, col_eos;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  string       tq[$];
  logic [22:0] vq[$];

  // reference model state
  logic        m_sc = 0, m_rc = 0, m_cc = 0;
  logic [20:0] m_sh = '0;
  logic [10:0] m_cst = '0, m_cp = '0;
  logic [9:0]  m_rst = '0, m_rp = '0;
  logic        m_ce = 0, m_re = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdo_window_addr i_rdo_window_addr (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .load_addr(load_addr), .row_sync(row_sync), .row_clk(row_clk),
    .col_sync(col_sync), .col_clk(col_clk), .row_ptr(row_ptr),
    .col_ptr(col_ptr), .row_eos(row_eos), .col_eos(col_eos)
  );

  // driver: one cycle of stimulus plus the expected outputs after the next edge
  task automatic step(input logic r, sc, sd, ld, rs, rc, cs, cc, input string tag);
    logic [10:0] ncs;
    logic [9:0]  nrs;
    logic        win;
    @(negedge clk);
    rst = r; ser_clk = sc; ser_dat = sd; load_addr = ld;
    row_sync = rs; row_clk = rc; col_sync = cs; col_clk = cc;
    if (r) begin
      m_sh = '0; m_cst = '0; m_rst = '0; m_cp = '0; m_rp = '0;
      m_ce = 0; m_re = 0; m_sc = 0; m_rc = 0; m_cc = 0;
    end else begin
      ncs = ld ? m_sh[20:10] : m_cst;
      nrs = ld ? m_sh[9:0]   : m_rst;
      win = (m_cst != 0) || (m_rst != 0);
      if (cs) begin m_cp = ncs; m_ce = 0; end
      else if (cc && !m_cc) begin
        m_ce = (m_cp == 11'd1278) && !win;
        m_cp = (m_cp == 11'd1279) ? 11'd0 : m_cp + 11'd1;
      end else m_ce = 0;
      if (rs) begin m_rp = nrs; m_re = 0; end
      else if (rc && !m_rc) begin
        m_re = (m_rp == 10'd1022) && !win;
        m_rp = (m_rp == 10'd1023) ? 10'd0 : m_rp + 10'd1;
      end else m_re = 0;
      if (sc && !m_sc) m_sh = {m_sh[19:0], sd};
      m_cst = ncs; m_rst = nrs;
      m_sc = sc; m_rc = rc; m_cc = cc;
    end
    tq.push_back(tag);
    vq.push_back({m_ce, m_re, m_cp, m_rp});
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic send_word(input logic [10:0] c, input logic [9:0] r);
    logic [20:0] w;
    w = {c, r};
    for (int i = 20; i >= 0; i--) begin
      step(0, 1, w[i], 0, 0, 0, 0, 0, "R2 shift");
      step(0, 0, w[i], 0, 0, 0, 0, 0, "R2 shift");
    end
  endtask

  task automatic col_pulses(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      step(0, 0, 0, 0, 0, 0, 0, 1, tag);
      step(0, 0, 0, 0, 0, 0, 0, 0, tag);
    end
  endtask

  task automatic row_pulses(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      step(0, 0, 0, 0, 0, 1, 0, 0, tag);
      step(0, 0, 0, 0, 0, 0, 0, 0, tag);
    end
  endtask

  // monitor: compare outputs a quarter period after each edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (tq.size() > 0) begin
        string       t;
        logic [22:0] e, a;
        t = tq.pop_front();
        e = vq.pop_front();
        a = {col_eos, row_eos, col_ptr, row_ptr};
        n_cmp++;
        if (a !== e) begin
          n_bad++;
          $display("FAIL %s: got col=%0d row=%0d ceos=%b reos=%b, expected col=%0d row=%0d ceos=%b reos=%b",
                   t, a[20:10], a[9:0], a[22], a[21], e[20:10], e[9:0], e[22], e[21]);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1; ser_clk = 0; ser_dat = 0; load_addr = 0;
    row_sync = 0; row_clk = 0; col_sync = 0; col_clk = 0;
    // R1 reset state
    step(1, 0, 0, 0, 0, 1, 0, 1, "R1 reset");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R1 reset");
    idle("R1 after reset");

    // R2 R3 R4 window start col=5 row=3
    send_word(11'd5, 10'd3);
    step(0, 0, 0, 1, 0, 0, 0, 0, "R3 load");
    step(0, 0, 0, 0, 1, 0, 1, 0, "R4 sync both");
    idle("R4 hold");

    // R6 column steps, level held high does not repeat
    col_pulses(3, "R6 col step");
    step(0, 0, 0, 0, 0, 0, 0, 1, "R6 rise");
    step(0, 0, 0, 0, 0, 0, 0, 1, "R6 held high");
    step(0, 0, 0, 0, 0, 0, 0, 1, "R6 held high");
    idle("R6 release");

    // R5 row steps
    row_pulses(4, "R5 row step");
    step(0, 0, 0, 0, 0, 1, 0, 0, "R5 rise");
    step(0, 0, 0, 0, 0, 1, 0, 0, "R5 held high");
    idle("R5 release");

    // R7 sync together with rising edge
    step(0, 0, 0, 0, 1, 1, 1, 1, "R7 sync wins");
    idle("R7 after");

    // R11 windowed scan reaches last column and row: no flags
    step(0, 0, 0, 0, 0, 0, 1, 0, "R11 col restart");
    col_pulses(1274, "R11 windowed line");
    step(0, 0, 0, 0, 1, 0, 0, 0, "R11 row restart");
    row_pulses(1020, "R11 windowed frame");

    // R8 load coincident with sync, new start zero
    send_word(11'd0, 10'd0);
    step(0, 0, 0, 1, 1, 0, 1, 0, "R8 load with sync");
    idle("R8 after");

    // R9 R12 full line
    col_pulses(1279, "R9 full line");
    col_pulses(1, "R12 col wrap");

    // R10 R12 full frame
    row_pulses(1023, "R10 full frame");
    row_pulses(1, "R12 row wrap");

    // R2 second word with different bits, then R3 load
    send_word(11'h5A3, 10'h2C5);
    step(0, 0, 0, 1, 0, 0, 0, 0, "R3 load 2");
    step(0, 0, 0, 0, 1, 0, 1, 0, "R2 sync check word");
    idle("R2 drain");
    idle("drain");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule